// File: doc/BRIEF.md
# NAND Asynchronous Bus Cycle Generator

This block turns single-byte requests into asynchronous SDR NAND flash bus cycles. A request names one of five operations: command latch, address latch, data write, data read, or busy wait. The block then drives chip enable, the command and address latch enables, the write and read strobes, and the data bus output enable. Strobe timing comes from programmable setup, hold and address-setup counts. These counts are measured in controller cycles. A busy wait watches the ready/busy pin and gives up after a programmable limit.

The block runs on an oversampling clock that is `OS_RATIO` (16) times the controller rate. A free-running phase counter marks one controller cycle out of every `OS_RATIO` clocks, and all strobe edges line up with those marks. Read data can be captured later than the strobe release, which suits extended-data-out parts. The extra delay is set in eighths of a reference period. The reference period is either the full controller period or half of it.

Top module: `nand_cycle_gen`

## Requirements
- R1: While reset is held and right after it, chip enable (`nand_ce_n`), both strobes and `tmo_flag` are high/low as idle: `nand_ce_n`=1, `nand_we_n`=1, `nand_re_n`=1, `nand_cle`=0, `nand_ale`=0, `nand_dq_oe`=0, `tmo_flag`=0. A strobe is only ever low while chip enable is low.
- R2: In command, address and write cycles, `nand_we_n` stays low for `cfg_data_setup` controller cycles. It then stays high for `cfg_data_hold` controller cycles before chip enable is released. One controller cycle is `OS_RATIO` clocks, and a count of zero acts as one. Only one strobe is low at a time.
- R3: Op code 0 (command) raises `nand_cle` and op code 1 (address) raises `nand_ale`. The latch enable is high for `cfg_addr_setup` controller cycles before `nand_we_n` falls and stays high to the end of the cycle. The two latch enables are never high together. Op code 2 (write) raises neither.
- R4: `nand_dq_oe` is high, and `nand_dq_out` carries the request byte, throughout command, address and write cycles. `nand_dq_oe` is low whenever `nand_re_n` is low.
- R5: Op code 3 (read) holds `nand_re_n` low for `cfg_data_setup` controller cycles. When the delay logic is off (`cfg_dly_en`=0) or the latched delay is zero, `rd_data` holds the value `nand_dq_in` had just before `nand_re_n` rose. `rd_valid` pulses once.
- R6: With the delay logic on and a nonzero latched delay N, `nand_dq_in` is sampled N×(`OS_RATIO`/8) clocks after `nand_re_n` rises when the half-reference bit is clear. With the bit set, the sample is taken N×(`OS_RATIO`/16) clocks after the rise.
- R7: `cfg_rd_dly` and `cfg_half_ref` are taken in only while `cfg_dly_en` is low. Changes made while it is high have no effect on the capture point.
- R8: After `cfg_dly_en` rises, `cmd_ready` stays low for at least `SETTLE_TICKS` (64) controller cycles.
- R9: Op code 4 (busy wait) keeps chip enable low until `nand_rb_n` is high. It then pulses `busy_done` and returns to idle.
- R10: If `nand_rb_n` stays low for more than `cfg_busy_tmo`×`TMO_UNIT` controller cycles, the busy wait ends. Chip enable goes high and `tmo_flag` rises and stays set until reset.
- R11: Op codes 5 to 7 are accepted and dropped: no strobe, latch enable or bus drive follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, OS_RATIO times the controller rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr_setup | input | CNT_W | Latch-enable lead before the write strobe, controller cycles |
| cfg_data_setup | input | CNT_W | Strobe low time, controller cycles |
| cfg_data_hold | input | CNT_W | Strobe high time, controller cycles |
| cfg_busy_tmo | input | TMO_W | Busy limit in units of TMO_UNIT controller cycles |
| cfg_rd_dly | input | DLY_W | Read capture delay in eighths of the reference period |
| cfg_half_ref | input | 1 | Reference period is half the controller period |
| cfg_dly_en | input | 1 | Enables delayed read capture |
| cmd_valid | input | 1 | Request present |
| cmd_op | input | 3 | Operation code |
| cmd_byte | input | 8 | Byte for command, address or write |
| cmd_ready | output | 1 | Request taken this clock |
| rd_valid | output | 1 | Read byte available pulse |
| rd_data | output | 8 | Captured read byte |
| busy_done | output | 1 | Busy wait ended in time (pulse) |
| tmo_flag | output | 1 | Sticky busy timeout |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus value to drive |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus value from the flash |
| nand_rb_n | input | 1 | Ready (1) / busy (0) |

## Verification
The bench keeps `OS_RATIO` at 16, `SETTLE_TICKS` at 64 and the 6-bit counts. With these values, full and half reference steps of two and one clock can be told apart by changing `nand_dq_in` on every clock after the read strobe rises. `TMO_UNIT` is lowered to 4, so a limit of 2 expires after 8 controller cycles. This puts both the in-time and the expired busy wait within a short run. The 64-cycle settle window after enabling the delay logic is measured against its bound.

// File: rtl/nbc_pkg.sv
package nbc_pkg;

    typedef enum logic [2:0] {
        OP_CMD  = 3'd0,
        OP_ADDR = 3'd1,
        OP_WR   = 3'd2,
        OP_RD   = 3'd3,
        OP_BUSY = 3'd4
    } nbc_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ASU,
        S_SETUP,
        S_HOLD,
        S_BUSY
    } nbc_state_e;

    typedef struct packed {
        logic ce_n;
        logic cle;
        logic ale;
        logic we_n;
        logic re_n;
        logic dq_oe;
    } nbc_pins_t;

    localparam nbc_pins_t PINS_IDLE = '{ce_n: 1'b1, cle: 1'b0, ale: 1'b0,
                                        we_n: 1'b1, re_n: 1'b1, dq_oe: 1'b0};

endpackage

// File: rtl/nbc_tick.sv
module nbc_tick #(
    parameter int OS_RATIO = 16
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = $clog2(OS_RATIO);

    logic [PW-1:0] phase_q;

    assign tick = (phase_q == PW'(OS_RATIO - 1));

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= tick ? '0 : phase_q + PW'(1);
    end
endmodule

// File: rtl/nbc_dly_gate.sv
module nbc_dly_gate #(
    parameter int DLY_W        = 4,
    parameter int SETTLE_TICKS = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             dly_en,
    input  logic [DLY_W-1:0] rd_dly_in,
    input  logic             half_in,
    output logic [DLY_W-1:0] rd_dly,
    output logic             half_ref,
    output logic             dly_on,
    output logic             settling
);
    localparam int SW = $clog2(SETTLE_TICKS + 1);

    logic          en_q;
    logic [SW-1:0] settle_q;
    logic          rise;

    assign rise     = dly_en & ~en_q;
    assign dly_on   = en_q;
    assign settling = rise | (settle_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            rd_dly   <= '0;
            half_ref <= 1'b0;
            settle_q <= '0;
        end else begin
            en_q <= dly_en;
            // delay settings only move while the delay logic is off
            if (!dly_en) begin
                rd_dly   <= rd_dly_in;
                half_ref <= half_in;
            end
            if (rise)
                settle_q <= SW'(SETTLE_TICKS);
            else if (tick && settle_q != '0)
                settle_q <= settle_q - SW'(1);
        end
    end
endmodule

// File: rtl/nbc_capture.sv
module nbc_capture #(
    parameter int OS_RATIO = 16,
    parameter int DLY_W    = 4,
    parameter int DQ_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             dly_on,
    input  logic [DLY_W-1:0] rd_dly,
    input  logic             half_ref,
    input  logic [DQ_W-1:0]  dq_in,
    output logic             pending,
    output logic             rd_valid,
    output logic [DQ_W-1:0]  rd_data
);
    localparam int STEP_FULL = OS_RATIO / 8;
    localparam int STEP_HALF = OS_RATIO / 16;
    localparam int DW        = $clog2(((1 << DLY_W) - 1) * STEP_FULL + 1) + 1;

    logic [DW-1:0] dly_ticks;
    logic [DW-1:0] dcnt_q;
    logic          bypass;

    assign dly_ticks = DW'(rd_dly) * (half_ref ? DW'(STEP_HALF) : DW'(STEP_FULL));
    assign bypass    = !dly_on || (rd_dly == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending  <= 1'b0;
            dcnt_q   <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (start && bypass) begin
                rd_data  <= dq_in;
                rd_valid <= 1'b1;
            end else if (start) begin
                pending <= 1'b1;
                dcnt_q  <= dly_ticks;
            end else if (pending) begin
                if (dcnt_q == DW'(1)) begin
                    rd_data  <= dq_in;
                    rd_valid <= 1'b1;
                    pending  <= 1'b0;
                end
                dcnt_q <= dcnt_q - DW'(1);
            end
        end
    end
endmodule

// File: rtl/nbc_seq.sv
module nbc_seq
    import nbc_pkg::*;
#(
    parameter int CNT_W    = 6,
    parameter int TMO_W    = 16,
    parameter int TMO_UNIT = 4096,
    parameter int DQ_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             settling,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [DQ_W-1:0]  cmd_byte,
    input  logic [CNT_W-1:0] asu,
    input  logic [CNT_W-1:0] dsu,
    input  logic [CNT_W-1:0] dho,
    input  logic [TMO_W-1:0] busy_tmo,
    input  logic             rb_n,
    input  logic             cap_pending,
    output logic             cmd_ready,
    output nbc_pins_t        pins,
    output logic [DQ_W-1:0]  dq_out,
    output logic             cap_start,
    output logic             busy_done,
    output logic             tmo_flag
);
    localparam int BW = TMO_W + $clog2(TMO_UNIT) + 1;

    nbc_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [2:0]       op_q;
    logic [BW-1:0]    bcnt_q;
    logic [BW-1:0]    limit;
    logic             accept;

    function automatic logic [CNT_W-1:0] ld(input logic [CNT_W-1:0] n);
        return (n == '0) ? '0 : n - CNT_W'(1);
    endfunction

    assign limit     = BW'(busy_tmo) * BW'(TMO_UNIT);
    assign cmd_ready = (state_q == S_IDLE) && tick && !settling;
    assign accept    = cmd_valid && cmd_ready;
    assign cap_start = (state_q == S_SETUP) && tick && (cnt_q == '0) && (op_q == OP_RD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            cnt_q     <= '0;
            op_q      <= '0;
            bcnt_q    <= '0;
            pins      <= PINS_IDLE;
            dq_out    <= '0;
            busy_done <= 1'b0;
            tmo_flag  <= 1'b0;
        end else begin
            busy_done <= 1'b0;
            case (state_q)
                S_IDLE: if (accept) begin
                    op_q   <= cmd_op;
                    dq_out <= cmd_byte;
                    case (cmd_op)
                        OP_CMD, OP_ADDR: begin
                            pins.ce_n  <= 1'b0;
                            pins.cle   <= (cmd_op == OP_CMD);
                            pins.ale   <= (cmd_op == OP_ADDR);
                            pins.dq_oe <= 1'b1;
                            if (asu != '0) begin
                                state_q <= S_ASU;
                                cnt_q   <= asu - CNT_W'(1);
                            end else begin
                                state_q   <= S_SETUP;
                                cnt_q     <= ld(dsu);
                                pins.we_n <= 1'b0;
                            end
                        end
                        OP_WR: begin
                            pins.ce_n  <= 1'b0;
                            pins.dq_oe <= 1'b1;
                            pins.we_n  <= 1'b0;
                            state_q    <= S_SETUP;
                            cnt_q      <= ld(dsu);
                        end
                        OP_RD: begin
                            pins.ce_n <= 1'b0;
                            pins.re_n <= 1'b0;
                            state_q   <= S_SETUP;
                            cnt_q     <= ld(dsu);
                        end
                        OP_BUSY: begin
                            pins.ce_n <= 1'b0;
                            bcnt_q    <= '0;
                            state_q   <= S_BUSY;
                        end
                        default: ;
                    endcase
                end
                S_ASU: if (tick) begin
                    if (cnt_q == '0) begin
                        state_q   <= S_SETUP;
                        cnt_q     <= ld(dsu);
                        pins.we_n <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                S_SETUP: if (tick) begin
                    if (cnt_q == '0) begin
                        state_q   <= S_HOLD;
                        cnt_q     <= ld(dho);
                        pins.we_n <= 1'b1;
                        pins.re_n <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                S_HOLD: if (tick) begin
                    if (cnt_q == '0 && !cap_pending) begin
                        state_q <= S_IDLE;
                        pins    <= PINS_IDLE;
                    end else if (cnt_q != '0) begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                S_BUSY: begin
                    if (rb_n) begin
                        busy_done <= 1'b1;
                        state_q   <= S_IDLE;
                        pins      <= PINS_IDLE;
                    end else if (tick) begin
                        if (bcnt_q >= limit) begin
                            tmo_flag <= 1'b1;
                            state_q  <= S_IDLE;
                            pins     <= PINS_IDLE;
                        end else begin
                            bcnt_q <= bcnt_q + BW'(1);
                        end
                    end
                end
                default: begin
                    state_q <= S_IDLE;
                    pins    <= PINS_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/nand_cycle_gen.sv
module nand_cycle_gen
    import nbc_pkg::*;
#(
    parameter int OS_RATIO     = 16,
    parameter int CNT_W        = 6,
    parameter int TMO_W        = 16,
    parameter int TMO_UNIT     = 4096,
    parameter int DLY_W        = 4,
    parameter int SETTLE_TICKS = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cfg_addr_setup,
    input  logic [CNT_W-1:0] cfg_data_setup,
    input  logic [CNT_W-1:0] cfg_data_hold,
    input  logic [TMO_W-1:0] cfg_busy_tmo,
    input  logic [DLY_W-1:0] cfg_rd_dly,
    input  logic             cfg_half_ref,
    input  logic             cfg_dly_en,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [7:0]       cmd_byte,
    output logic             cmd_ready,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             busy_done,
    output logic             tmo_flag,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_dq_out,
    output logic             nand_dq_oe,
    input  logic [7:0]       nand_dq_in,
    input  logic             nand_rb_n
);
    logic             tick;
    logic             settling;
    logic             dly_on;
    logic             half_q;
    logic [DLY_W-1:0] rd_dly_q;
    logic             cap_start;
    logic             cap_pending;
    nbc_pins_t        pins;

    nbc_tick #(.OS_RATIO(OS_RATIO)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    nbc_dly_gate #(.DLY_W(DLY_W), .SETTLE_TICKS(SETTLE_TICKS)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .dly_en   (cfg_dly_en),
        .rd_dly_in(cfg_rd_dly),
        .half_in  (cfg_half_ref),
        .rd_dly   (rd_dly_q),
        .half_ref (half_q),
        .dly_on   (dly_on),
        .settling (settling)
    );

    nbc_seq #(.CNT_W(CNT_W), .TMO_W(TMO_W), .TMO_UNIT(TMO_UNIT), .DQ_W(8)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .settling   (settling),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_byte   (cmd_byte),
        .asu        (cfg_addr_setup),
        .dsu        (cfg_data_setup),
        .dho        (cfg_data_hold),
        .busy_tmo   (cfg_busy_tmo),
        .rb_n       (nand_rb_n),
        .cap_pending(cap_pending),
        .cmd_ready  (cmd_ready),
        .pins       (pins),
        .dq_out     (nand_dq_out),
        .cap_start  (cap_start),
        .busy_done  (busy_done),
        .tmo_flag   (tmo_flag)
    );

    nbc_capture #(.OS_RATIO(OS_RATIO), .DLY_W(DLY_W), .DQ_W(8)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .start   (cap_start),
        .dly_on  (dly_on),
        .rd_dly  (rd_dly_q),
        .half_ref(half_q),
        .dq_in   (nand_dq_in),
        .pending (cap_pending),
        .rd_valid(rd_valid),
        .rd_data (rd_data)
    );

    assign nand_ce_n  = pins.ce_n;
    assign nand_cle   = pins.cle;
    assign nand_ale   = pins.ale;
    assign nand_we_n  = pins.we_n;
    assign nand_re_n  = pins.re_n;
    assign nand_dq_oe = pins.dq_oe;
endmodule

// File: rtl/nand_cycle_gen_chk.sv
module nand_cycle_gen_chk (
    input logic clk,
    input logic rst,
    input logic cfg_dly_en,
    input logic cmd_ready,
    input logic busy_done,
    input logic tmo_flag,
    input logic nand_ce_n,
    input logic nand_cle,
    input logic nand_ale,
    input logic nand_we_n,
    input logic nand_re_n,
    input logic nand_dq_oe
);
    a_r1_strobe_needs_ce: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

    a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(!nand_we_n && !nand_re_n));

    a_r3_latch_excl: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));

    a_r4_bus_off_in_read: assert property (@(posedge clk) disable iff (rst)
        !nand_re_n |-> !nand_dq_oe);

    a_r8_settle_now: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_dly_en) |-> !cmd_ready);

    a_r8_settle_next: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_dly_en) |=> !cmd_ready);

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        busy_done |=> !busy_done);

    a_r10_tmo_sticky: assert property (@(posedge clk) disable iff (rst)
        tmo_flag |=> tmo_flag);
endmodule

bind nand_cycle_gen nand_cycle_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_dly_en(cfg_dly_en),
    .cmd_ready (cmd_ready),
    .busy_done (busy_done),
    .tmo_flag  (tmo_flag),
    .nand_ce_n (nand_ce_n),
    .nand_cle  (nand_cle),
    .nand_ale  (nand_ale),
    .nand_we_n (nand_we_n),
    .nand_re_n (nand_re_n),
    .nand_dq_oe(nand_dq_oe)
);

// File: tb/nand_cycle_gen_tb_top.sv
module nand_cycle_gen_tb_top;
    localparam int OS     = 16;
    localparam int TUNIT  = 4;
    localparam logic [7:0] LOWV = 8'hA5;
    localparam logic [7:0] BASE = 8'h40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] cfg_addr_setup = 6'd2;
    logic [5:0] cfg_data_setup = 6'd3;
    logic [5:0] cfg_data_hold  = 6'd2;
    logic [15:0] cfg_busy_tmo  = 16'd2;
    logic [3:0] cfg_rd_dly = 4'd5;
    logic       cfg_half_ref = 1'b0;
    logic       cfg_dly_en = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] cmd_byte = 8'd0;
    logic       cmd_ready, rd_valid, busy_done, tmo_flag;
    logic [7:0] rd_data, nand_dq_out;
    logic       nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0] nand_dq_in = 8'h00;
    logic       nand_rb_n = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    int rd_seen = 0;
    int done_seen = 0;
    logic [7:0] exp_q[$];
    string      req_q[$];
    bit         reported = 1'b0;

    always #10 clk = ~clk;

    nand_cycle_gen #(.TMO_UNIT(TUNIT)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_addr_setup(cfg_addr_setup), .cfg_data_setup(cfg_data_setup),
        .cfg_data_hold(cfg_data_hold), .cfg_busy_tmo(cfg_busy_tmo),
        .cfg_rd_dly(cfg_rd_dly), .cfg_half_ref(cfg_half_ref), .cfg_dly_en(cfg_dly_en),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_ready(cmd_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy_done(busy_done), .tmo_flag(tmo_flag),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb_n(nand_rb_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
    endtask

    // monitor: pops expected read bytes as the design returns them
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            rd_seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R5", "unexpected read data", int'(rd_data), -1);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string r = req_q.pop_front();
                check(rd_data == e, r, "read byte", int'(rd_data), int'(e));
            end
        end
        if (!rst && busy_done) done_seen++;
    end

    task automatic issue(input logic [2:0] op, input logic [7:0] b, output int waited);
        @(negedge clk);
        cmd_op = op; cmd_byte = b; cmd_valid = 1'b1; waited = 0;
        while (!cmd_ready) begin
            @(negedge clk);
            waited++;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!nand_ce_n) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic run_write(input logic [2:0] op, input logic [7:0] b,
                             input int e_pre, input int e_low, input int e_high);
        int w, pre, low, high, bad;
        logic e_cle, e_ale;
        e_cle = (op == 3'd0);
        e_ale = (op == 3'd1);
        issue(op, b, w);
        pre = 0; low = 0; high = 0; bad = 0;
        while (nand_we_n) begin
            pre++;
            if (nand_cle != e_cle || nand_ale != e_ale || !nand_dq_oe) bad++;
            @(negedge clk);
        end
        while (!nand_we_n) begin
            low++;
            if (nand_cle != e_cle || nand_ale != e_ale) bad++;
            if (!nand_dq_oe || nand_dq_out != b) bad++;
            @(negedge clk);
        end
        while (!nand_ce_n) begin
            high++;
            if (nand_cle != e_cle || nand_ale != e_ale || !nand_dq_oe) bad++;
            @(negedge clk);
        end
        check(pre == e_pre, "R3", "latch lead before strobe", pre, e_pre);
        check(low == e_low, "R2", "strobe low clocks", low, e_low);
        check(high == e_high, "R2", "strobe high clocks", high, e_high);
        check(bad == 0, "R4", "bus drive / latch level violations", bad, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_read(input logic [7:0] e, input string req, input int e_low);
        int w, low, bad, seen0;
        seen0 = rd_seen;
        nand_dq_in = LOWV;
        exp_q.push_back(e);
        req_q.push_back(req);
        issue(3'd3, 8'h00, w);
        low = 0; bad = 0;
        while (!nand_re_n) begin
            low++;
            if (nand_dq_oe) bad++;
            @(negedge clk);
        end
        for (int k = 0; k < 40; k++) begin
            nand_dq_in = BASE + 8'(k);
            @(negedge clk);
        end
        wait_idle();
        check(low == e_low, "R5", "read strobe low clocks", low, e_low);
        check(bad == 0, "R4", "bus driven during read strobe", bad, 0);
        check(rd_seen == seen0 + 1, req, "read results returned", rd_seen - seen0, 1);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        report();
        $finish;
    end

    initial begin
        int w, cnt, bad, d0;
        repeat (3) @(negedge clk);
        check(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe,
              "R1", "pins during reset", 0, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe,
              "R1", "pins after reset", 0, 0);
        check(!tmo_flag && !rd_valid, "R1", "flags after reset", int'(tmo_flag), 0);

        // R3 command latch: lead 2, setup 3, hold 2 controller cycles
        run_write(3'd0, 8'h70, 2 * OS, 3 * OS, 2 * OS);
        cfg_addr_setup = 6'd1;
        run_write(3'd1, 8'h2C, 1 * OS, 3 * OS, 2 * OS);
        // R2 write, then zero counts acting as one
        run_write(3'd2, 8'h5A, 0, 3 * OS, 2 * OS);
        cfg_data_setup = 6'd0; cfg_data_hold = 6'd0;
        run_write(3'd2, 8'hC3, 0, OS, OS);
        cfg_data_setup = 6'd3; cfg_data_hold = 6'd2;

        // R5 bypass with delay logic off
        run_read(LOWV, "R5", 3 * OS);

        // R8 settle window, R6 full reference delay 3 -> 6 clocks
        cfg_rd_dly = 4'd3; cfg_half_ref = 1'b0;
        @(negedge clk);
        cfg_dly_en = 1'b1;
        issue(3'd0, 8'hFF, w);
        check(w >= 64 * OS && w <= 66 * OS, "R8", "clocks until accept after enable", w, 64 * OS);
        wait_idle();
        run_read(BASE + 8'd5, "R6", 3 * OS);

        // R7 change while enabled is ignored
        cfg_rd_dly = 4'd7; cfg_half_ref = 1'b1;
        repeat (3) @(negedge clk);
        run_read(BASE + 8'd5, "R7", 3 * OS);

        // R6 half reference, delay 7 -> 7 clocks
        cfg_dly_en = 1'b0;
        repeat (3) @(negedge clk);
        cfg_dly_en = 1'b1;
        run_read(BASE + 8'd6, "R6", 3 * OS);

        // R5 zero delay with logic on is bypass
        cfg_dly_en = 1'b0; cfg_rd_dly = 4'd0;
        repeat (3) @(negedge clk);
        cfg_dly_en = 1'b1;
        run_read(LOWV, "R5", 3 * OS);

        // R9 busy wait ending in time
        d0 = done_seen;
        nand_rb_n = 1'b0;
        issue(3'd4, 8'h00, w);
        repeat (40) @(negedge clk);
        check(!nand_ce_n, "R9", "chip enable held while busy", int'(nand_ce_n), 0);
        nand_rb_n = 1'b1;
        repeat (3) @(negedge clk);
        check(done_seen == d0 + 1, "R9", "done pulses", done_seen - d0, 1);
        check(nand_ce_n && !tmo_flag, "R9", "idle without timeout", int'(tmo_flag), 0);
        repeat (20) @(negedge clk);

        // R10 timeout: 2 units of 4 controller cycles
        d0 = done_seen;
        nand_rb_n = 1'b0;
        issue(3'd4, 8'h00, w);
        cnt = 0;
        while (!tmo_flag) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt >= 8 * OS && cnt <= 10 * OS, "R10", "clocks to timeout", cnt, 8 * OS);
        check(nand_ce_n, "R10", "chip enable released on timeout", int'(nand_ce_n), 1);
        nand_rb_n = 1'b1;
        repeat (40) @(negedge clk);
        check(tmo_flag, "R10", "timeout flag sticky", int'(tmo_flag), 1);
        check(done_seen == d0, "R10", "no done pulse on timeout", done_seen - d0, 0);

        // R11 undefined op codes drop silently
        issue(3'd6, 8'h11, w);
        bad = 0;
        for (int k = 0; k < 100; k++) begin
            if (!nand_ce_n || !nand_we_n || !nand_re_n || nand_cle || nand_ale || nand_dq_oe) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R11", "pin activity after undefined op", bad, 0);
        run_write(3'd2, 8'h99, 0, 3 * OS, 2 * OS);

        check(exp_q.size() == 0, "R5", "unreturned reads", exp_q.size(), 0);
        report();
        $finish;
    end
endmodule